// File: doc/BRIEF.md
# Relocatable Vector Table Fetch Unit

This unit converts an exception number into the address of that exception's entry in an in-memory vector table. It reads the entry over a single-outstanding request/ready read port and returns the handler start address with either a valid flag or an error flag. The table base sits in a register that a privileged agent can move. The unit keeps the base within a bounded window and aligned to a 128-byte boundary.

When reset is released, the unit runs a boot sequence without being asked. It first reads table entry 0, which holds the initial stack pointer, and returns that word unmodified with a stack-pointer marker. It then reads entry 1, the reset handler, and returns it as an ordinary vector response. Only after that does it accept requests. Every handler word it fetches must have bit 0 set. The address it returns always has bit 0 cleared. A word with bit 0 clear, or a bus error, produces an error response.

States: `ST_BOOT_SP` reads entry 0 and moves to `ST_BOOT_RV` on success, or to `ST_IDLE` on a bus error. `ST_BOOT_RV` reads entry 1 and moves to `ST_IDLE` on completion. `ST_IDLE` accepts a request and moves to `ST_FETCH`. `ST_FETCH` moves back to `ST_IDLE` on completion. A read completes in the cycle where `mem_req` and `mem_ready` are both high.

Top module: `vec_fetch_unit`

## Requirements
- R1: During and right after reset, the base reads 0x00000000, `mem_req` is high with `mem_addr` 0x00000000, `req_ready` is low and no response is flagged.
- R2: The boot sequence first returns the entry-0 word unmodified, with `rsp_valid` and `rsp_is_sp` both 1, even if its bit 0 is 0. It then reads base+4 and returns that word as a vector response with `rsp_is_sp` 0. After that `req_ready` rises.
- R3: A request accepted for exception number N reads address base + 4*N, using the base value held in the cycle of acceptance.
- R4: A base write takes effect only when `cfg_priv` is 1 and 0x00000080 <= `cfg_wdata` <= 0x3FFFFF80. The stored value has bits [6:0] forced to zero.
- R5: A base write with `cfg_priv` 0, or with a value outside the legal window, leaves the base unchanged.
- R6: A fetched vector with bit 0 = 1 gives `rsp_valid` = 1 with `rsp_addr` = the word with bit 0 cleared. A vector with bit 0 = 0 gives `rsp_err` = 1, `rsp_valid` = 0 and `rsp_addr` = 0. `rsp_valid` and `rsp_err` are never both 1.
- R7: When `mem_err` is 1 on completion, the response is `rsp_err` = 1 with `rsp_addr` = 0, and the unit returns to idle with `mem_req` low.
- R8: `req_ready` is 1 only when no read is in flight. A `req_valid` seen while `req_ready` is 0 is dropped and starts no read.
- R9: Once raised, `mem_req` stays high with an unchanged `mem_addr` until `mem_ready` is seen.
- R10: Response flags are registered. They are high for exactly the one cycle after the completing cycle.
- R11: If a legal base write and a request acceptance fall in the same cycle, that fetch uses the old base and later fetches use the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Base register write strobe |
| cfg_priv | input | 1 | Write comes from a privileged agent |
| cfg_wdata | input | 32 | Proposed base value |
| cfg_base | output | 32 | Current table base |
| req_valid | input | 1 | Fetch request |
| req_excnum | input | 9 | Exception number to fetch |
| req_ready | output | 1 | Unit idle, request accepted this cycle |
| mem_req | output | 1 | Read request to memory |
| mem_addr | output | 32 | Read address |
| mem_ready | input | 1 | Read completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_err | input | 1 | Bus error, valid with mem_ready |
| rsp_valid | output | 1 | Good response |
| rsp_err | output | 1 | Error response |
| rsp_addr | output | 32 | Handler address, or the stack pointer word |
| rsp_is_sp | output | 1 | Response is the boot stack-pointer word |

## Verification
Two pairs of events can land in the same cycle. A legal base write can coincide with the acceptance of a request. The bench provokes this by raising `cfg_we` and `req_valid` on the same edge. It then judges the result by comparing `mem_addr` against the old base plus four times N, and `cfg_base` against the new value. In the other pair, a response is still pending while a new request arrives. The bench pokes `req_valid` during memory wait states and checks that `req_ready` is low and that no second read begins after the response.

// File: rtl/vtab_pkg.sv
package vtab_pkg;

    typedef enum logic [1:0] {
        ST_BOOT_SP = 2'd0,
        ST_BOOT_RV = 2'd1,
        ST_IDLE    = 2'd2,
        ST_FETCH   = 2'd3
    } vt_state_e;

    localparam int unsigned ENTRY_SHIFT = 2;

endpackage

// File: rtl/vtab_base_reg.sv
module vtab_base_reg #(
    parameter int unsigned AW       = 32,
    parameter int unsigned ALIGN    = 7,
    parameter logic [31:0] BASE_MIN = 32'h0000_0080,
    parameter logic [31:0] BASE_MAX = 32'h3FFF_FF80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          priv,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] base_q
);
    localparam logic [AW-1:0] LOW_MASK = AW'((64'd1 << ALIGN) - 64'd1);
    localparam logic [AW-1:0] MIN_A    = AW'(BASE_MIN);
    localparam logic [AW-1:0] MAX_A    = AW'(BASE_MAX);

    logic in_window;
    logic accept;

    always_comb begin
        in_window = (wdata >= MIN_A) && (wdata <= MAX_A);
        accept    = we && priv && in_window;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (accept) begin
            base_q <= wdata & ~LOW_MASK;
        end
    end

    // R5: writes from unprivileged agents leave the base alone
    a_r5_unpriv_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !priv) |=> $stable(base_q));

    // R5: out-of-window values leave the base alone
    a_r5_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we && ((wdata < MIN_A) || (wdata > MAX_A))) |=> $stable(base_q));

    // R4: a stored base always lies inside the window or is the reset value
    a_r4_window: assert property (@(posedge clk) disable iff (!rst_n)
        (base_q == '0) || ((base_q >= (MIN_A & ~LOW_MASK)) && (base_q <= MAX_A)));

endmodule

// File: rtl/vtab_addr_gen.sv
module vtab_addr_gen
    import vtab_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned EXC_W = 9
) (
    input  logic [AW-1:0]    base,
    input  logic [EXC_W-1:0] excnum,
    output logic [AW-1:0]    entry_addr
);
    logic [AW-1:0] offset;

    always_comb begin
        offset     = AW'(excnum) << ENTRY_SHIFT;
        entry_addr = base + offset;
    end

endmodule

// File: rtl/vtab_fetch_fsm.sv
module vtab_fetch_fsm
    import vtab_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned EXC_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [EXC_W-1:0] req_excnum,
    output logic             req_ready,
    output logic [EXC_W-1:0] sel_excnum,
    input  logic [AW-1:0]    entry_addr,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_ready,
    input  logic [AW-1:0]    mem_rdata,
    input  logic             mem_err,
    output logic             rsp_valid,
    output logic             rsp_err,
    output logic [AW-1:0]    rsp_addr,
    output logic             rsp_is_sp
);
    localparam logic [EXC_W-1:0] RESET_ENTRY = EXC_W'(1);

    vt_state_e state_q, state_nx;
    logic      done;
    logic      accept;

    always_comb begin
        mem_req    = (state_q != ST_IDLE);
        req_ready  = (state_q == ST_IDLE);
        done       = mem_req && mem_ready;
        accept     = req_ready && req_valid;
        sel_excnum = (state_q == ST_IDLE) ? req_excnum : RESET_ENTRY;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_BOOT_SP: if (done) state_nx = mem_err ? ST_IDLE : ST_BOOT_RV;
            ST_BOOT_RV: if (done) state_nx = ST_IDLE;
            ST_IDLE:    if (req_valid) state_nx = ST_FETCH;
            ST_FETCH:   if (done) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BOOT_SP;
        else        state_q <= state_nx;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_addr  <= '0;
            rsp_is_sp <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_is_sp <= 1'b0;
            if (accept) begin
                mem_addr <= entry_addr;
            end
            if (done && (state_q == ST_BOOT_SP) && !mem_err) begin
                mem_addr <= entry_addr;
            end
            if (done) begin
                rsp_is_sp <= (state_q == ST_BOOT_SP);
                if (mem_err) begin
                    rsp_err  <= 1'b1;
                    rsp_addr <= '0;
                end else if (state_q == ST_BOOT_SP) begin
                    rsp_valid <= 1'b1;
                    rsp_addr  <= mem_rdata;
                end else if (mem_rdata[0]) begin
                    rsp_valid <= 1'b1;
                    rsp_addr  <= {mem_rdata[AW-1:1], 1'b0};
                end else begin
                    rsp_err  <= 1'b1;
                    rsp_addr <= '0;
                end
            end
        end
    end

    // R9: a pending read keeps its request and address
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    // R10: a response flag follows a completing cycle
    a_r10_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || rsp_err) |-> $past(mem_req && mem_ready));

    // R6: returned vectors never carry bit 0, and the flags are exclusive
    a_r6_lowbit: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_is_sp) |-> !rsp_addr[0]);
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid, rsp_err}));

    // R7: a bus error ends in an error response and idle
    a_r7_bus_err: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_err) |=> (rsp_err && !mem_req));

    // R8: a request seen while busy starts nothing
    a_r8_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && !mem_ready) |=> (state_q == ST_FETCH));

endmodule

// File: rtl/vec_fetch_unit.sv
module vec_fetch_unit #(
    parameter int unsigned AW       = 32,
    parameter int unsigned EXC_W    = 9,
    parameter int unsigned ALIGN    = 7,
    parameter logic [31:0] BASE_MIN = 32'h0000_0080,
    parameter logic [31:0] BASE_MAX = 32'h3FFF_FF80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_priv,
    input  logic [AW-1:0]    cfg_wdata,
    output logic [AW-1:0]    cfg_base,
    input  logic             req_valid,
    input  logic [EXC_W-1:0] req_excnum,
    output logic             req_ready,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_ready,
    input  logic [AW-1:0]    mem_rdata,
    input  logic             mem_err,
    output logic             rsp_valid,
    output logic             rsp_err,
    output logic [AW-1:0]    rsp_addr,
    output logic             rsp_is_sp
);
    logic [EXC_W-1:0] sel_excnum;
    logic [AW-1:0]    entry_addr;

    vtab_base_reg #(
        .AW(AW), .ALIGN(ALIGN), .BASE_MIN(BASE_MIN), .BASE_MAX(BASE_MAX)
    ) u_base (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .priv(cfg_priv),
        .wdata(cfg_wdata), .base_q(cfg_base)
    );

    vtab_addr_gen #(.AW(AW), .EXC_W(EXC_W)) u_addr (
        .base(cfg_base), .excnum(sel_excnum), .entry_addr(entry_addr)
    );

    vtab_fetch_fsm #(.AW(AW), .EXC_W(EXC_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_excnum(req_excnum), .req_ready(req_ready),
        .sel_excnum(sel_excnum), .entry_addr(entry_addr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .mem_err(mem_err),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_addr(rsp_addr),
        .rsp_is_sp(rsp_is_sp)
    );

    // R1: while the boot read of entry 0 is pending, the address is zero
    a_r1_boot_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !req_ready && $past(!rst_n)) |-> (mem_addr == '0));

endmodule

// File: tb/tb_vec_fetch_unit.sv
module tb_vec_fetch_unit;
    localparam int EXC_W = 9;
    localparam int NUM_EXC = 1 << EXC_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0, cfg_priv = 1'b0;
    logic [31:0]      cfg_wdata = '0;
    logic [31:0]      cfg_base;
    logic             req_valid = 1'b0;
    logic [EXC_W-1:0] req_excnum = '0;
    logic             req_ready;
    logic             mem_req;
    logic [31:0]      mem_addr;
    logic             mem_ready = 1'b0;
    logic [31:0]      mem_rdata = '0;
    logic             mem_err = 1'b0;
    logic             rsp_valid, rsp_err, rsp_is_sp;
    logic [31:0]      rsp_addr;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 0;
    logic [31:0] base_m = '0;

    vec_fetch_unit dut (.*);

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // called at a negedge with mem_req high; returns at the negedge after completion
    task automatic respond(int waits, logic [31:0] data, bit err, logic [31:0] exp_a, bit poke);
        for (int i = 0; i < waits; i++) begin
            chk("R9 mem_req held", 32'(mem_req), 1);
            chk("R9 mem_addr held", mem_addr, exp_a);
            if (poke) begin
                chk("R8 not ready while busy", 32'(req_ready), 0);
                req_valid = 1'b1;
                req_excnum = EXC_W'(30);
            end
            @(negedge clk);
            req_valid = 1'b0;
        end
        chk("R9 mem_addr at completion", mem_addr, exp_a);
        mem_ready = 1'b1;
        mem_rdata = data;
        mem_err = err;
        @(negedge clk);
        mem_ready = 1'b0;
        mem_err = 1'b0;
    endtask

    task automatic check_vec_rsp(logic [31:0] data, bit err);
        bit bad;
        bad = err || !data[0];
        chk(err ? "R7 rsp_err" : "R6 rsp_err", 32'(rsp_err), 32'(bad));
        chk("R6 rsp_valid", 32'(rsp_valid), 32'(!bad));
        chk("R6 rsp_addr", rsp_addr, bad ? 32'h0 : (data & ~32'h1));
        chk("R2 rsp_is_sp low", 32'(rsp_is_sp), 0);
    endtask

    task automatic fetch(int n, int waits, logic [31:0] data, bit err, bit poke);
        logic [31:0] exp_a;
        exp_a = base_m + 32'(n) * 4;
        chk("R8 ready in idle", 32'(req_ready), 1);
        req_valid = 1'b1;
        req_excnum = EXC_W'(n);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3 mem_req", 32'(mem_req), 1);
        chk("R3 entry address", mem_addr, exp_a);
        respond(waits, data, err, exp_a, poke);
        check_vec_rsp(data, err);
        chk("R7 back to idle", 32'(mem_req), 0);
        @(negedge clk);
        chk("R10 response one cycle", 32'(rsp_valid | rsp_err), 0);
        chk("R8 no dropped request started", 32'(mem_req), 0);
    endtask

    task automatic write_base(bit priv, logic [31:0] v);
        logic [31:0] mask_v;
        cfg_we = 1'b1;
        cfg_priv = priv;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        mask_v = v & ~32'h7F;
        if (priv && v >= 32'h80 && v <= 32'h3FFF_FF80) begin
            base_m = mask_v;
            chk("R4 base written", cfg_base, base_m);
        end else begin
            chk("R5 base unchanged", cfg_base, base_m);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 base in reset", cfg_base, 0);
        chk("R1 ready low in reset", 32'(req_ready), 0);
        rst_n = 1'b1;
        chk("R1 boot mem_req", 32'(mem_req), 1);
        chk("R1 boot address", mem_addr, 0);
        chk("R1 no response", 32'(rsp_valid | rsp_err), 0);
        // R2: boot sequence, stack pointer word has bit 0 clear and passes through
        respond(2, 32'h2000_1000, 1'b0, 32'h0, 1'b0);
        chk("R2 sp valid", 32'(rsp_valid), 1);
        chk("R2 sp marker", 32'(rsp_is_sp), 1);
        chk("R2 sp word", rsp_addr, 32'h2000_1000);
        chk("R2 reset vector address", mem_addr, 32'h4);
        chk("R2 ready low during boot", 32'(req_ready), 0);
        respond(1, 32'h0000_0201, 1'b0, 32'h4, 1'b0);
        chk("R2 reset vector valid", 32'(rsp_valid), 1);
        chk("R2 reset vector marker", 32'(rsp_is_sp), 0);
        chk("R2 reset vector addr", rsp_addr, 32'h200);
        chk("R2 ready after boot", 32'(req_ready), 1);
        @(negedge clk);

        // R4 / R5: base write legality sweep
        write_base(1'b1, 32'h0000_007F);
        write_base(1'b0, 32'h0000_1000);
        write_base(1'b1, 32'h3FFF_FF81);
        write_base(1'b1, 32'hFFFF_FF80);
        write_base(1'b1, 32'h0001_2345);
        write_base(1'b1, 32'h0000_0085);
        write_base(1'b0, 32'h0000_0200);
        write_base(1'b1, 32'h3FFF_FFFF);

        // R3 / R6 / R7 / R9 / R10: sweep all exception numbers at three bases
        for (int b = 0; b < 3; b++) begin
            if (b == 1) write_base(1'b1, 32'h0000_0080);
            if (b == 2) write_base(1'b1, 32'h3FFF_FF80);
            for (int n = 0; n < NUM_EXC; n++) begin
                logic [31:0] d;
                d = ((base_m + 32'(n) * 4) * 5 + 32'h1000) | 32'h1;
                if (n % 7 == 3) d = d & ~32'h1;
                fetch(n, n % 3, d, (n % 11 == 5), 1'b0);
            end
        end

        // R8: requests while busy are dropped
        fetch(20, 3, 32'h0000_4441, 1'b0, 1'b1);

        // R11: base write and acceptance in the same cycle
        chk("R11 ready", 32'(req_ready), 1);
        cfg_we = 1'b1;
        cfg_priv = 1'b1;
        cfg_wdata = 32'h0000_8000;
        req_valid = 1'b1;
        req_excnum = EXC_W'(16);
        @(negedge clk);
        cfg_we = 1'b0;
        req_valid = 1'b0;
        chk("R11 fetch uses old base", mem_addr, base_m + 32'd64);
        chk("R11 new base stored", cfg_base, 32'h0000_8000);
        respond(0, 32'h0000_0301, 1'b0, base_m + 32'd64, 1'b0);
        check_vec_rsp(32'h0000_0301, 1'b0);
        base_m = 32'h0000_8000;
        @(negedge clk);
        fetch(16, 1, 32'h0000_0401, 1'b0, 1'b0);

        // R7: bus error on the boot stack pointer read skips the reset vector
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        base_m = '0;
        respond(0, 32'h0, 1'b1, 32'h0, 1'b0);
        chk("R7 boot err flag", 32'(rsp_err), 1);
        chk("R7 boot err marker", 32'(rsp_is_sp), 1);
        chk("R7 boot err to idle", 32'(req_ready), 1);
        chk("R7 no reset vector read", 32'(mem_req), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule